// File: doc/BRIEF.md
# Four-step search motion estimator

This block finds the motion vector of one 4x4 luma block inside a reference area that allows displacements from -7 to +7 on each axis. The host first loads the current block and an 18x18 window of reference pixels through a simple write port. It then pulses `start`. A controller walks a four-step block-matching pattern. A serial datapath scores each candidate with a sum of absolute differences (SAD), and the lowest score seen so far is tracked.

The search always scores the zero displacement first. Its first stage then looks at the eight points two pixels away. While the winner of a stage is not the stage centre, the 5x5 window moves onto the winner and only the points not yet covered are scored: five after a corner win, three after an edge-middle win. A centre win ends this part of the search, and so does a third 5x5 stage. A final stage then scores the eight one-pixel neighbours of the best point. The result is given as two signed 4-bit components and the minimum SAD, marked by a one-cycle `done` pulse.

Top module: `fss_motion_est`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. Addresses 0..15 hold the current block at row*4+col. Addresses 16..339 hold the reference window at 16+row*18+col. The pixel compared with current pixel (r,c) for displacement (dx,dy) is reference row dy+7+r, column dx+7+c.
- R2: The cost of a candidate is the sum of |current - reference| over all 16 pixel pairs. `min_sad` at `done` equals that sum for the reported vector.
- R3: The zero displacement is scored before any other point. If it still wins after the first 5x5 stage, the search goes directly to the one-pixel final stage.
- R4: A stage that is not the first re-centres the 5x5 window (step 2) on the previous winner and scores only the points that lie outside the previous window. That is five points after a corner win and three after an edge-middle win.
- R5: At most two re-centred 5x5 stages follow the first one. After that the final stage is forced, around the current best point.
- R6: The final stage scores the eight neighbours at step 1 around the best point. The best of those nine points is the reported vector.
- R7: A candidate replaces the held best only when its SAD is strictly lower, so on equal SAD the earlier point stays.
- R8: Each scored point costs 17 cycles, the centre included. Each stage adds 9 cycles. `done` is high for exactly one cycle, 17 + sum over stages of (9 + 17*points) rising edges after the edge that took `start`.
- R9: A `start` pulse while a search is running is ignored and does not change its result or timing.
- R10: After a synchronous active-low reset, `done` is 0, both vector components are 0 and `min_sad` is 0.
- R11: `mv_x` and `mv_y` are two's-complement 4-bit values in the range -7..+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Pixel write strobe |
| wr_addr | input | 9 | Pixel address (current block then reference window) |
| wr_data | input | 8 | Pixel value |
| start | input | 1 | Begins a search when idle |
| done | output | 1 | One-cycle pulse: result valid |
| mv_x | output | 4 | Horizontal displacement, signed |
| mv_y | output | 4 | Vertical displacement, signed |
| min_sad | output | 12 | SAD of the reported vector |

## Verification
The result time depends on the data, because every stage scores a data-dependent number of points. The bench model therefore counts the scored points of each stage and derives the exact edge, 17 + sum of (9 + 17*points) after the start edge, where `done` must rise. On every clock in between, the bench checks at the falling edge that `done` is low. On the predicted cycle it checks `done`, both vector components and the SAD. The cycle after it must show `done` low again. An extra `start` sent mid-search must leave that predicted edge unchanged.

// File: rtl/fss_me_pkg.sv
// Shared types and helpers for the four-step search motion estimator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fss_me_pkg;

    // Controller phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_CMP,
        ST_EVAL,
        ST_STEP,
        ST_DONE
    } fss_state_t;

    // Unit x offset of neighbour k (0..7) in raster order around a centre.
    function automatic int nb_dx(input int k);
        int pos;
        pos = (k < 4) ? k : k + 1;
        return (pos % 3) - 1;
    endfunction

    // Unit y offset of neighbour k (0..7) in raster order around a centre.
    function automatic int nb_dy(input int k);
        int pos;
        pos = (k < 4) ? k : k + 1;
        return (pos / 3) - 1;
    endfunction

endpackage

// File: rtl/fss_me_store.sv
// Pixel storage: the current block and the reference window, held in flops.
// Written through one address space; read combinationally by the SAD path.
// Assumes addresses beyond the reference window are never written.
module fss_me_store #(
    parameter int BLK    = 4,
    parameter int WIN    = 18,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 9
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [PIX_W-1:0]             wr_data,
    input  logic [$clog2(BLK*BLK)-1:0]   cur_idx,
    input  logic [$clog2(WIN)-1:0]       ref_row,
    input  logic [$clog2(WIN)-1:0]       ref_col,
    output logic [PIX_W-1:0]             cur_pix,
    output logic [PIX_W-1:0]             ref_pix
);
    localparam int CUR_N = BLK * BLK;
    localparam int REF_N = WIN * WIN;
    localparam int CI_W  = $clog2(CUR_N);
    localparam int RI_W  = $clog2(REF_N);

    logic [PIX_W-1:0] cur_mem [CUR_N];
    logic [PIX_W-1:0] ref_mem [REF_N];
    logic [RI_W-1:0]  rd_idx;
    logic [RI_W-1:0]  wr_ref_idx;

    // Map the flat write address onto the two arrays.
    assign wr_ref_idx = RI_W'(int'(wr_addr) - CUR_N);

    // Store incoming pixels.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (int'(wr_addr) < CUR_N)
                cur_mem[wr_addr[CI_W-1:0]] <= wr_data;
            else if (int'(wr_addr) < CUR_N + REF_N)
                ref_mem[wr_ref_idx] <= wr_data;
        end
    end

    // Serve the pixel pair the SAD path asks for.
    assign rd_idx  = RI_W'(int'(ref_row) * WIN + int'(ref_col));
    assign cur_pix = cur_mem[cur_idx];
    assign ref_pix = ref_mem[rd_idx];

endmodule

// File: rtl/fss_me_sad.sv
// Serial SAD accumulator: adds one absolute pixel difference per enabled
// clock; the first pixel of a candidate restarts the sum.
// Assumes at most BLK*BLK pixels per candidate so SAD_W never overflows.
module fss_me_sad #(
    parameter int PIX_W = 8,
    parameter int SAD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [SAD_W-1:0] sad
);
    logic [PIX_W-1:0] diff;

    // Absolute difference of the pixel pair.
    assign diff = (a > b) ? (a - b) : (b - a);

    // Accumulate, restarting on the first pixel of each candidate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sad <= '0;
        else if (en)
            sad <= (first ? '0 : sad) + SAD_W'(diff);
    end

    // Within one candidate the running sum never falls (R2).
    p_sum_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first) |=> (sad >= $past(sad)));

endmodule

// File: rtl/fss_me_ctrl.sv
// Search controller: walks the centre point, the step-2 stages with the
// overlap filter, and the step-1 final stage; tracks the best candidate.
// Assumes the SAD accumulator holds a full sum in the cycle after the
// last pixel of a candidate.
module fss_me_ctrl
    import fss_me_pkg::*;
#(
    parameter int BLK     = 4,
    parameter int MAX_D   = 7,
    parameter int REPEATS = 2,
    parameter int MV_W    = 4,
    parameter int SAD_W   = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [SAD_W-1:0]                     sad_val,
    output logic                                 sad_en,
    output logic                                 sad_first,
    output logic [$clog2(BLK*BLK)-1:0]           cur_idx,
    output logic [$clog2(BLK+2*MAX_D)-1:0]       ref_row,
    output logic [$clog2(BLK+2*MAX_D)-1:0]       ref_col,
    output logic                                 done,
    output logic signed [MV_W-1:0]               mv_x,
    output logic signed [MV_W-1:0]               mv_y,
    output logic [SAD_W-1:0]                     min_sad
);
    localparam int PIX_N = BLK * BLK;
    localparam int PC_W  = $clog2(PIX_N);
    localparam int RC_W  = $clog2(BLK + 2 * MAX_D);
    localparam int REP_W = $clog2(REPEATS + 1);

    fss_state_t               state;
    logic [PC_W-1:0]          pix;
    logic [2:0]               idx;
    logic signed [MV_W-1:0]   ctr_x, ctr_y, prev_x, prev_y;
    logic signed [MV_W-1:0]   cand_x, cand_y, best_x, best_y;
    logic                     has_prev, is_final, first_cand;
    logic [REP_W-1:0]         rep_cnt;
    logic [SAD_W-1:0]         best_sad;
    int                       nx, ny, step, row_i, col_i;
    logic                     in_rng, seen, nb_ok;

    // Neighbour idx of the current stage centre, and whether to score it.
    always_comb begin
        step   = is_final ? 1 : 2;
        nx     = int'(ctr_x) + step * nb_dx(int'(idx));
        ny     = int'(ctr_y) + step * nb_dy(int'(idx));
        in_rng = (nx >= -MAX_D) && (nx <= MAX_D) && (ny >= -MAX_D) && (ny <= MAX_D);
        seen   = has_prev && (nx - int'(prev_x) >= -2) && (nx - int'(prev_x) <= 2)
                          && (ny - int'(prev_y) >= -2) && (ny - int'(prev_y) <= 2);
        nb_ok  = in_rng && !seen;
    end

    // Pixel addresses for the candidate being accumulated.
    always_comb begin
        row_i   = int'(cand_y) + MAX_D + int'(pix) / BLK;
        col_i   = int'(cand_x) + MAX_D + int'(pix) % BLK;
        ref_row = RC_W'(row_i);
        ref_col = RC_W'(col_i);
    end

    assign cur_idx   = pix;
    assign sad_en    = (state == ST_ACC);
    assign sad_first = (pix == '0);
    assign done      = (state == ST_DONE);
    assign mv_x      = best_x;
    assign mv_y      = best_y;
    assign min_sad   = best_sad;

    // Sequence the search and keep the best candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pix        <= '0;
            idx        <= '0;
            ctr_x      <= '0;
            ctr_y      <= '0;
            prev_x     <= '0;
            prev_y     <= '0;
            cand_x     <= '0;
            cand_y     <= '0;
            best_x     <= '0;
            best_y     <= '0;
            best_sad   <= '0;
            has_prev   <= 1'b0;
            is_final   <= 1'b0;
            first_cand <= 1'b0;
            rep_cnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_ACC;
                    pix        <= '0;
                    idx        <= '0;
                    ctr_x      <= '0;
                    ctr_y      <= '0;
                    cand_x     <= '0;
                    cand_y     <= '0;
                    has_prev   <= 1'b0;
                    is_final   <= 1'b0;
                    rep_cnt    <= '0;
                    first_cand <= 1'b1;
                end
                ST_ACC: begin
                    pix <= pix + 1'b1;
                    if (int'(pix) == PIX_N - 1)
                        state <= ST_CMP;
                end
                ST_CMP: begin
                    if (first_cand || sad_val < best_sad) begin
                        best_sad <= sad_val;
                        best_x   <= cand_x;
                        best_y   <= cand_y;
                    end
                    first_cand <= 1'b0;
                    if (first_cand) begin
                        idx   <= '0;
                        state <= ST_EVAL;
                    end else if (idx == 3'd7) begin
                        state <= ST_STEP;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (nb_ok) begin
                        cand_x <= MV_W'(nx);
                        cand_y <= MV_W'(ny);
                        pix    <= '0;
                        state  <= ST_ACC;
                    end else if (idx == 3'd7) begin
                        state <= ST_STEP;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_STEP: begin
                    idx <= '0;
                    if (is_final) begin
                        state <= ST_DONE;
                    end else if ((best_x == ctr_x && best_y == ctr_y) ||
                                 rep_cnt == REP_W'(REPEATS)) begin
                        is_final <= 1'b1;
                        has_prev <= 1'b0;
                        ctr_x    <= best_x;
                        ctr_y    <= best_y;
                        state    <= ST_EVAL;
                    end else begin
                        prev_x   <= ctr_x;
                        prev_y   <= ctr_y;
                        has_prev <= 1'b1;
                        ctr_x    <= best_x;
                        ctr_y    <= best_y;
                        rep_cnt  <= rep_cnt + 1'b1;
                        state    <= ST_EVAL;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The zero displacement is the first point scored (R3).
    p_centre_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_ACC && cand_x == '0 && cand_y == '0));

    // Stage limit forces the final stage (R5).
    p_forced_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && !is_final && rep_cnt == REP_W'(REPEATS)) |=> is_final);

    // The held best never gets worse after the centre (R7).
    p_best_no_worse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && !first_cand) |=> (best_sad <= $past(best_sad)));

    // Done lasts one cycle (R8).
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A start while busy does not restart the search (R9).
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !first_cand && start) |=> !first_cand);

    // Vector components stay inside the search range (R11).
    p_mv_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(best_x) >= -MAX_D && int'(best_x) <= MAX_D &&
         int'(best_y) >= -MAX_D && int'(best_y) <= MAX_D));

endmodule

// File: rtl/fss_motion_est.sv
// Four-step search motion estimator top: pixel storage, serial SAD path
// and search controller. Pixels are loaded before start; results are
// valid while done is high.
module fss_motion_est #(
    parameter int BLK     = 4,
    parameter int MAX_D   = 7,
    parameter int REPEATS = 2,
    parameter int PIX_W   = 8,
    parameter int MV_W    = 4,
    localparam int WIN    = BLK + 2 * MAX_D,
    localparam int ADDR_W = $clog2(BLK * BLK + WIN * WIN),
    localparam int SAD_W  = $clog2(BLK * BLK * (2 ** PIX_W - 1) + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [PIX_W-1:0]         wr_data,
    input  logic                     start,
    output logic                     done,
    output logic signed [MV_W-1:0]   mv_x,
    output logic signed [MV_W-1:0]   mv_y,
    output logic [SAD_W-1:0]         min_sad
);
    localparam int CI_W = $clog2(BLK * BLK);
    localparam int RC_W = $clog2(WIN);

    logic [CI_W-1:0]  cur_idx;
    logic [RC_W-1:0]  ref_row, ref_col;
    logic [PIX_W-1:0] cur_pix, ref_pix;
    logic [SAD_W-1:0] sad_val;
    logic             sad_en, sad_first;

    fss_me_store #(.BLK(BLK), .WIN(WIN), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur_idx (cur_idx),
        .ref_row (ref_row),
        .ref_col (ref_col),
        .cur_pix (cur_pix),
        .ref_pix (ref_pix)
    );

    fss_me_sad #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_sad (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sad_en),
        .first (sad_first),
        .a     (cur_pix),
        .b     (ref_pix),
        .sad   (sad_val)
    );

    fss_me_ctrl #(.BLK(BLK), .MAX_D(MAX_D), .REPEATS(REPEATS),
                  .MV_W(MV_W), .SAD_W(SAD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sad_val   (sad_val),
        .sad_en    (sad_en),
        .sad_first (sad_first),
        .cur_idx   (cur_idx),
        .ref_row   (ref_row),
        .ref_col   (ref_col),
        .done      (done),
        .mv_x      (mv_x),
        .mv_y      (mv_y),
        .min_sad   (min_sad)
    );

endmodule

// File: tb/fss_motion_est_test.sv
// Bench: loads pixel patterns, runs searches, and compares every clock
// against a behavioural model of the search and its cycle cost.
module fss_motion_est_test;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              start = 1'b0;
    logic              done;
    logic signed [3:0] mv_x, mv_y;
    logic [11:0]       min_sad;

    int n_chk = 0;
    int n_fail = 0;
    int cur [16];
    int refm [324];

    always #5 clk = ~clk;

    fss_motion_est uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .done(done),
        .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // SAD from the address map of R1 and the cost of R2.
    function automatic int cost(input int dx, input int dy);
        int s = 0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                s += iabs(cur[r*4+c] - refm[(dy+7+r)*18 + dx+7+c]);
        return s;
    endfunction

    // Behavioural search: results and the edge count of R8.
    task automatic model(output int ex, output int ey, output int es, output int ncyc);
        int cx = 0, cy = 0, px = 0, py = 0, bx = 0, by = 0, bs, st, v, x, y, s, pos;
        bit hp = 0, fin = 0;
        int rep = 0;
        bs = cost(0, 0);
        ncyc = 17;
        forever begin
            st = fin ? 1 : 2;
            v = 0;
            for (int k = 0; k < 8; k++) begin
                pos = (k < 4) ? k : k + 1;
                x = cx + st * ((pos % 3) - 1);
                y = cy + st * ((pos / 3) - 1);
                if (iabs(x) <= 7 && iabs(y) <= 7 &&
                    !(hp && iabs(x - px) <= 2 && iabs(y - py) <= 2)) begin
                    v++;
                    s = cost(x, y);
                    if (s < bs) begin bs = s; bx = x; by = y; end
                end
            end
            ncyc += 9 + 17 * v;
            if (fin) break;
            if ((bx == cx && by == cy) || rep == 2) begin
                fin = 1; hp = 0; cx = bx; cy = by;
            end else begin
                px = cx; py = cy; hp = 1; cx = bx; cy = by; rep++;
            end
        end
        ex = bx; ey = by; es = bs;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Fill the window with texture kind, copy block at (tx,ty), add noise.
    task automatic load(input int kind, input int tx, input int ty, input int noise);
        for (int y = 0; y < 18; y++)
            for (int x = 0; x < 18; x++) begin
                case (kind)
                    0: refm[y*18+x] = 100;
                    1: refm[y*18+x] = ((x - 3) * (x - 3) + 2 * (y - 11) * (y - 11)) / 3 % 256;
                    default: refm[y*18+x] = ((x * 37 + y * 91 + x * y * 13) ^ (x << 3)) & 255;
                endcase
            end
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                cur[r*4+c] = (refm[(ty+7+r)*18 + tx+7+c] + noise * ((r + c) % 2)) & 255;
        for (int i = 0; i < 16; i++) wr(i, cur[i]);
        for (int i = 0; i < 324; i++) wr(16 + i, refm[i]);
    endtask

    task automatic search(input string tag, input bit poke);
        int ex, ey, es, n, k;
        model(ex, ey, es, n);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        k = 1;
        while (k <= n + 2) begin
            if (poke && k == 6) start = 1'b1;
            if (poke && k == 7) start = 1'b0;
            chk(done == (k == n + 1), {tag, " R3 R4 R5 R8 R9 done timing"}, int'(done), int'(k == n + 1));
            if (k == n + 1) begin
                chk(int'(mv_x) == ex, {tag, " R1 R6 R7 R11 mv_x"}, int'(mv_x), ex);
                chk(int'(mv_y) == ey, {tag, " R1 R6 R7 R11 mv_y"}, int'(mv_y), ey);
                chk(int'(min_sad) == es, {tag, " R2 min_sad"}, int'(min_sad), es);
            end
            @(posedge clk); @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R10 done after reset", int'(done), 0);
        chk(mv_x == 4'sd0 && mv_y == 4'sd0, "R10 mv after reset", int'(mv_x), 0);
        chk(min_sad == 12'd0, "R10 sad after reset", int'(min_sad), 0);

        load(0, 0, 0, 0);   search("flat ties R7 centre R3", 1'b0);
        load(1, 2, -2, 0);  search("bowl corner", 1'b0);
        load(1, 4, 0, 0);   search("bowl edge", 1'b0);
        load(1, 6, -6, 3);  search("bowl far R5", 1'b0);
        load(2, -7, 7, 0);  search("hash extreme", 1'b0);
        load(2, 3, -1, 5);  search("hash busy start R9", 1'b1);
        load(1, -5, 3, 0);  search("bowl second busy R9", 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired R8 actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule